// File: doc/BRIEF.md
# Background Check Scheduler

This block decides when background integrity and consistency checks run against storage partitions. Each check type has its own countdown timer. A countdown is loaded from a shared 40-bit pseudo-random source, ANDed with a mask that comes from that type's period register. Checks therefore start at random times, but the gap between two checks never exceeds a bound that software sets. Software can also start a single check of either type through a trigger register. This works even when both timers are off.

A request line for each check type stays high until the checker acknowledges it. A pending output shows that at least one check is outstanding. A cycle-count watchdog watches each outstanding request. If the request is not acknowledged in time, a sticky fatal timeout error is raised. A second sticky flag reports an illegal state in either scheduler state machine.

Configuration uses a simple write port with two lock bits. One lock bit guards the period and timeout registers. The other guards the trigger register. Once a lock bit is cleared, only reset sets it again.

Each check type runs the same state machine with three named states:
- `CH_IDLE` (timer off)
- `CH_WAIT` (countdown running)
- `CH_BUSY` (request raised)

The transitions are:
- idle-to-wait when the period becomes non-zero
- wait-to-idle when the period returns to zero
- idle-to-busy and wait-to-busy on a software trigger
- wait-to-busy on countdown expiry
- busy-to-wait or busy-to-idle on acknowledge, depending on whether the timer is enabled
- any illegal encoding to idle, which raises the state error

Top module: `bgchk_top`

## Requirements
- R1: The random source is a 40-bit maximal-length Galois LFSR. It steps every cycle and never holds zero, so consecutive automatic intervals vary.
- R2: The 40-bit mask for a check type is its 32-bit period value shifted left by 8, with the low 8 bits set to ones. The countdown is loaded with the LFSR value ANDed with this mask. An automatic request rises no more than mask+3 cycles after the period is written or after the previous request is acknowledged.
- R3: A period value of 0 disables that type's timer. Period 0 is the reset value, so with no trigger no request is ever raised.
- R4: Integrity checks use request/acknowledge index 0 and period address 0. Consistency checks use index 1 and period address 1. The two types run independently.
- R5: A write to trigger address 4 starts a one-off check. Bit 0 selects integrity and bit 1 selects consistency. The bits clear themselves, and they work with the timers disabled. The request rises two cycles after the write.
- R6: A request stays high until its acknowledge is sampled, and drops in the following cycle. The pending output is 1 exactly when any request is high.
- R7: A software trigger or a timer expiry that arrives while a check of the same type is already pending merges with it. A single acknowledge retires the merged request.
- R8: The timeout value is at address 2. With a limit T≠0, if no acknowledge is sampled on any of the first T rising edges after the request rose, the timeout error sets on the T-th edge. The error stays set until reset. T=0 disables the watchdog.
- R9: The configuration lock is at address 3. It resets to 1 and is cleared by writing a value with bit 0 equal to 0. Writing 1 does not set it again. While it is 0, writes to the period and timeout registers are ignored.
- R10: The trigger lock is at address 5 and behaves in the same way. While it is 0, writes to the trigger register are ignored.
- R11: The state error flag is 0 through all legal operation. An illegal state encoding sets it, and it stays set until reset.
- R12: After reset, both requests, pending and both error flags are 0, and both lock outputs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register address |
| cfg_wdata_i | input | 32 | Configuration write data |
| chk_ack_i | input | 2 | Check done, per type (0 integrity, 1 consistency) |
| chk_req_o | output | 2 | Check request, per type |
| chk_pending_o | output | 1 | Any check outstanding |
| timeout_err_o | output | 1 | Sticky fatal check timeout |
| fsm_err_o | output | 1 | Sticky fatal illegal-state error |
| cfg_wen_o | output | 1 | Period/timeout lock bit |
| trig_wen_o | output | 1 | Trigger lock bit |

## Verification
The assertions check these properties on every cycle:
- The LFSR is never zero.
- A request holds until it is acknowledged.
- The timeout error is sticky and rises only after a non-zero limit was set.
- The state error is sticky.
- Both lock bits, once cleared, stay cleared.
- A trigger pulse appears only when the trigger lock was open.

Some behaviour cannot be stated as a single-cycle property, so only the bench scenarios can show it:
- The bound on automatic intervals, and that the intervals vary.
- The exact edge on which the timeout fires.
- That locked writes are ignored.
- That repeated triggers and timer expiries merge into one request.

// File: rtl/bgchk_pkg.sv
package bgchk_pkg;
    localparam int unsigned NUM_CHK     = 2;
    localparam int unsigned CHK_INTEG   = 0;
    localparam int unsigned CHK_CONSIST = 1;

    localparam int unsigned ADDR_W      = 3;
    localparam int unsigned REG_W       = 32;
    localparam int unsigned LFSR_W      = 40;
    localparam int unsigned FILL_W      = LFSR_W - REG_W;

    localparam logic [ADDR_W-1:0] A_PER_INTEG   = 3'd0;
    localparam logic [ADDR_W-1:0] A_PER_CONSIST = 3'd1;
    localparam logic [ADDR_W-1:0] A_TIMEOUT     = 3'd2;
    localparam logic [ADDR_W-1:0] A_CFG_LOCK    = 3'd3;
    localparam logic [ADDR_W-1:0] A_TRIGGER     = 3'd4;
    localparam logic [ADDR_W-1:0] A_TRIG_LOCK   = 3'd5;

    typedef enum logic [1:0] {
        CH_IDLE = 2'b00,
        CH_WAIT = 2'b01,
        CH_BUSY = 2'b10
    } ch_state_e;
endpackage

// File: rtl/bgchk_lfsr.sv
module bgchk_lfsr #(
    parameter int unsigned         WIDTH = 40,
    parameter logic [WIDTH-1:0]    TAPS  = 40'hA0_0014_0000,
    parameter logic [WIDTH-1:0]    SEED  = 40'hA5_C3E1_9D07
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic [WIDTH-1:0] value_o
);
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;

    always_comb begin
        state_d = state_q >> 1;
        if (state_q[0]) begin
            state_d = state_d ^ TAPS;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= SEED;
        end else begin
            state_q <= state_d;
        end
    end

    assign value_o = state_q;

    // R1
    lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q != '0);
endmodule

// File: rtl/bgchk_cfg.sv
module bgchk_cfg
    import bgchk_pkg::*;
(
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic                             we_i,
    input  logic [ADDR_W-1:0]                addr_i,
    input  logic [REG_W-1:0]                 wdata_i,
    output logic [NUM_CHK-1:0][REG_W-1:0]    period_o,
    output logic [REG_W-1:0]                 tmo_limit_o,
    output logic [NUM_CHK-1:0]               trig_o,
    output logic                             cfg_wen_o,
    output logic                             trig_wen_o
);
    logic [NUM_CHK-1:0][REG_W-1:0] period_q;
    logic [REG_W-1:0]              tmo_q;
    logic [NUM_CHK-1:0]            trig_q;
    logic                          cfg_wen_q;
    logic                          trig_wen_q;

    logic hit_per_integ, hit_per_consist, hit_tmo, hit_cfg_lock;
    logic hit_trig, hit_trig_lock;

    always_comb begin
        hit_per_integ   = we_i && (addr_i == A_PER_INTEG);
        hit_per_consist = we_i && (addr_i == A_PER_CONSIST);
        hit_tmo         = we_i && (addr_i == A_TIMEOUT);
        hit_cfg_lock    = we_i && (addr_i == A_CFG_LOCK);
        hit_trig        = we_i && (addr_i == A_TRIGGER);
        hit_trig_lock   = we_i && (addr_i == A_TRIG_LOCK);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            period_q   <= '0;
            tmo_q      <= '0;
            trig_q     <= '0;
            cfg_wen_q  <= 1'b1;
            trig_wen_q <= 1'b1;
        end else begin
            if (cfg_wen_q && hit_per_integ) begin
                period_q[CHK_INTEG] <= wdata_i;
            end
            if (cfg_wen_q && hit_per_consist) begin
                period_q[CHK_CONSIST] <= wdata_i;
            end
            if (cfg_wen_q && hit_tmo) begin
                tmo_q <= wdata_i;
            end
            if (hit_cfg_lock && !wdata_i[0]) begin
                cfg_wen_q <= 1'b0;
            end
            if (hit_trig_lock && !wdata_i[0]) begin
                trig_wen_q <= 1'b0;
            end
            if (trig_wen_q && hit_trig) begin
                trig_q <= wdata_i[NUM_CHK-1:0];
            end else begin
                trig_q <= '0;
            end
        end
    end

    assign period_o    = period_q;
    assign tmo_limit_o = tmo_q;
    assign trig_o      = trig_q;
    assign cfg_wen_o   = cfg_wen_q;
    assign trig_wen_o  = trig_wen_q;

    // R9
    cfg_lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_wen_q |=> !cfg_wen_q);

    // R10
    trig_lock_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trig_wen_q |=> !trig_wen_q);

    // R10
    trig_needs_wen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trig_q != '0) |-> $past(trig_wen_q));
endmodule

// File: rtl/bgchk_chan.sv
module bgchk_chan
    import bgchk_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [REG_W-1:0]  period_i,
    input  logic [REG_W-1:0]  tmo_limit_i,
    input  logic [LFSR_W-1:0] lfsr_i,
    input  logic              trig_i,
    input  logic              ack_i,
    output logic              req_o,
    output logic              tmo_err_o,
    output logic              fsm_err_o
);
    ch_state_e          state_q, state_d;
    logic [LFSR_W-1:0]  cnt_q, cnt_d;
    logic [REG_W-1:0]   tmo_cnt_q, tmo_cnt_d;
    logic               tmo_err_q, tmo_err_d;
    logic               fsm_err_q, fsm_err_d;

    logic [LFSR_W-1:0]  mask;
    logic [LFSR_W-1:0]  draw;
    logic               timer_on;
    logic               cnt_zero;
    logic               tmo_hit;

    always_comb begin
        mask     = {period_i, {FILL_W{1'b1}}};
        draw     = lfsr_i & mask;
        timer_on = (period_i != '0);
        cnt_zero = (cnt_q == '0);
        tmo_hit  = (tmo_limit_i != '0) && (tmo_cnt_q == (tmo_limit_i - 32'd1));
    end

    // next-state process
    always_comb begin
        state_d   = state_q;
        cnt_d     = cnt_q;
        fsm_err_d = fsm_err_q;
        unique case (state_q)
            CH_IDLE: begin
                if (trig_i) begin
                    state_d = CH_BUSY;
                    cnt_d   = draw;
                end else if (timer_on) begin
                    state_d = CH_WAIT;
                    cnt_d   = draw;
                end
            end
            CH_WAIT: begin
                if (trig_i) begin
                    state_d = CH_BUSY;
                    cnt_d   = draw;
                end else if (!timer_on) begin
                    state_d = CH_IDLE;
                end else if (cnt_zero) begin
                    state_d = CH_BUSY;
                    cnt_d   = draw;
                end else begin
                    cnt_d = cnt_q - 40'd1;
                end
            end
            CH_BUSY: begin
                if (timer_on) begin
                    cnt_d = cnt_zero ? draw : (cnt_q - 40'd1);
                end
                if (ack_i) begin
                    state_d = timer_on ? CH_WAIT : CH_IDLE;
                end
            end
            default: begin
                state_d   = CH_IDLE;
                cnt_d     = '0;
                fsm_err_d = 1'b1;
            end
        endcase
    end

    // watchdog next-state
    always_comb begin
        tmo_cnt_d = '0;
        tmo_err_d = tmo_err_q;
        if (state_q == CH_BUSY && !ack_i) begin
            tmo_cnt_d = (tmo_cnt_q == '1) ? tmo_cnt_q : (tmo_cnt_q + 32'd1);
            if (tmo_hit) begin
                tmo_err_d = 1'b1;
            end
        end
    end

    // state register process
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q   <= CH_IDLE;
            cnt_q     <= '0;
            tmo_cnt_q <= '0;
            tmo_err_q <= 1'b0;
            fsm_err_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            cnt_q     <= cnt_d;
            tmo_cnt_q <= tmo_cnt_d;
            tmo_err_q <= tmo_err_d;
            fsm_err_q <= fsm_err_d;
        end
    end

    // output process
    always_comb begin
        req_o     = (state_q == CH_BUSY);
        tmo_err_o = tmo_err_q;
        fsm_err_o = fsm_err_q;
    end

    // R6
    req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_o && !ack_i |=> req_o);

    // R8
    tmo_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmo_err_q |=> tmo_err_q);

    // R8
    tmo_needs_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(tmo_err_q) |-> ($past(tmo_limit_i) != '0));

    // R11
    fsm_err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fsm_err_q |=> fsm_err_q);
endmodule

// File: rtl/bgchk_top.sv
module bgchk_top
    import bgchk_pkg::*;
#(
    parameter logic [LFSR_W-1:0] LFSR_SEED = 40'hA5_C3E1_9D07
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                cfg_we_i,
    input  logic [ADDR_W-1:0]   cfg_addr_i,
    input  logic [REG_W-1:0]    cfg_wdata_i,
    input  logic [NUM_CHK-1:0]  chk_ack_i,
    output logic [NUM_CHK-1:0]  chk_req_o,
    output logic                chk_pending_o,
    output logic                timeout_err_o,
    output logic                fsm_err_o,
    output logic                cfg_wen_o,
    output logic                trig_wen_o
);
    logic [LFSR_W-1:0]             lfsr_val;
    logic [NUM_CHK-1:0][REG_W-1:0] period;
    logic [REG_W-1:0]              tmo_limit;
    logic [NUM_CHK-1:0]            trig;
    logic [NUM_CHK-1:0]            req;
    logic [NUM_CHK-1:0]            tmo_err;
    logic [NUM_CHK-1:0]            fsm_err;

    bgchk_lfsr #(
        .WIDTH (LFSR_W),
        .SEED  (LFSR_SEED)
    ) u_lfsr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .value_o (lfsr_val)
    );

    bgchk_cfg u_cfg (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .we_i        (cfg_we_i),
        .addr_i      (cfg_addr_i),
        .wdata_i     (cfg_wdata_i),
        .period_o    (period),
        .tmo_limit_o (tmo_limit),
        .trig_o      (trig),
        .cfg_wen_o   (cfg_wen_o),
        .trig_wen_o  (trig_wen_o)
    );

    for (genvar gi = 0; gi < NUM_CHK; gi++) begin : g_chan
        bgchk_chan u_chan (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .period_i    (period[gi]),
            .tmo_limit_i (tmo_limit),
            .lfsr_i      (lfsr_val),
            .trig_i      (trig[gi]),
            .ack_i       (chk_ack_i[gi]),
            .req_o       (req[gi]),
            .tmo_err_o   (tmo_err[gi]),
            .fsm_err_o   (fsm_err[gi])
        );
    end

    assign chk_req_o     = req;
    assign chk_pending_o = |req;
    assign timeout_err_o = |tmo_err;
    assign fsm_err_o     = |fsm_err;
endmodule

// File: tb/bgchk_top_bench.sv
`timescale 1ns/1ps
module bgchk_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [1:0]  ack = '0;
    logic [1:0]  req;
    logic        pending, tmo_err, fsm_err, cfg_wen, trig_wen;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    bgchk_top u_bgchk_top (
        .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(we), .cfg_addr_i(addr),
        .cfg_wdata_i(wdata), .chk_ack_i(ack), .chk_req_o(req),
        .chk_pending_o(pending), .timeout_err_o(tmo_err), .fsm_err_o(fsm_err),
        .cfg_wen_o(cfg_wen), .trig_wen_o(trig_wen)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; we = 1'b0; ack = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic wait_req(input int idx, input int limit, output int n);
        n = 0;
        while (!req[idx] && n <= limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic ack_one(input int idx);
        ack[idx] = 1'b1;
        @(negedge clk);
        ack[idx] = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        check("R12 req", req, 2'b00);
        check("R12 pending", pending, 0);
        check("R12 tmo_err", tmo_err, 0);
        check("R12 fsm_err", fsm_err, 0);
        check("R12 locks", {cfg_wen, trig_wen}, 2'b11);
    endtask

    task automatic t_disabled();
        int seen = 0;
        do_reset();
        repeat (2000) begin
            @(negedge clk);
            if (req != 0) seen++;
        end
        check("R3 no request with period 0", seen, 0);
    endtask

    task automatic t_sw_trigger();
        do_reset();
        wr(3'd4, 32'h1);
        check("R5 not yet one cycle after write", req, 2'b00);
        @(negedge clk);
        check("R5 integrity trigger", req, 2'b01);
        check("R6 pending high", pending, 1);
        ack_one(0);
        check("R6 request drops after ack", req, 2'b00);
        check("R6 pending low", pending, 0);
        wr(3'd4, 32'h2);
        @(negedge clk);
        check("R4 consistency trigger on index 1 only", req, 2'b10);
        ack_one(1);
        check("R6 consistency drops", req, 2'b00);
        check("R11 no fsm error", fsm_err, 0);
    endtask

    task automatic t_merge_sw();
        int seen = 0;
        do_reset();
        wr(3'd4, 32'h1);
        @(negedge clk);
        wr(3'd4, 32'h1);
        wr(3'd4, 32'h1);
        repeat (3) @(negedge clk);
        check("R7 still one pending", req, 2'b01);
        ack_one(0);
        repeat (50) begin
            @(negedge clk);
            if (req != 0) seen++;
        end
        check("R7 merged triggers retired by one ack", seen, 0);
    endtask

    task automatic t_auto_bound();
        int n;
        int gaps[6];
        int other = 0;
        int differ = 0;
        do_reset();
        wr(3'd0, 32'h1);
        for (int k = 0; k < 6; k++) begin
            n = 0;
            while (!req[0] && n <= 600) begin
                @(negedge clk);
                n++;
                if (req[1]) other++;
            end
            gaps[k] = n;
            check("R2 interval within mask+3", (n <= 32'h1FF + 3), 1);
            ack_one(0);
        end
        for (int k = 1; k < 6; k++) if (gaps[k] != gaps[0]) differ++;
        check("R1 intervals vary", (differ > 0), 1);
        check("R4 consistency idle while integrity timer runs", other, 0);
    endtask

    task automatic t_merge_timer();
        int n;
        int drop = 0;
        do_reset();
        wr(3'd1, 32'h1);
        wait_req(1, 600, n);
        check("R2 consistency auto request", req[1], 1);
        repeat (1200) begin
            @(negedge clk);
            if (!req[1]) drop++;
        end
        check("R6 request held without ack", drop, 0);
        ack_one(1);
        check("R7 one ack retires merged expiries", req[1], 0);
        wr(3'd1, 32'h0);
        if (req[1]) ack_one(1);
    endtask

    task automatic t_timeout_ok();
        do_reset();
        wr(3'd2, 32'd5);
        wr(3'd4, 32'h1);
        @(negedge clk);
        check("R5 trigger for timeout", req[0], 1);
        repeat (4) @(negedge clk);
        ack_one(0);
        check("R8 ack on 5th edge avoids timeout", tmo_err, 0);
    endtask

    task automatic t_timeout_fire();
        do_reset();
        wr(3'd2, 32'd5);
        wr(3'd4, 32'h1);
        @(negedge clk);
        repeat (4) @(negedge clk);
        check("R8 no error before 5th edge", tmo_err, 0);
        @(negedge clk);
        check("R8 error at 5th edge", tmo_err, 1);
        ack_one(0);
        repeat (5) @(negedge clk);
        check("R8 error sticky", tmo_err, 1);
        check("R11 fsm error clear", fsm_err, 0);
    endtask

    task automatic t_cfg_lock();
        int seen = 0;
        do_reset();
        wr(3'd3, 32'h0);
        check("R9 lock cleared", cfg_wen, 0);
        wr(3'd3, 32'h1);
        check("R9 lock not re-set", cfg_wen, 0);
        wr(3'd0, 32'h1);
        wr(3'd2, 32'd3);
        repeat (1500) begin
            @(negedge clk);
            if (req != 0) seen++;
        end
        check("R9 period write ignored", seen, 0);
        wr(3'd4, 32'h1);
        repeat (20) @(negedge clk);
        check("R9 timeout write ignored", tmo_err, 0);
        ack_one(0);
    endtask

    task automatic t_trig_lock();
        int seen = 0;
        do_reset();
        wr(3'd5, 32'h0);
        check("R10 trigger lock cleared", trig_wen, 0);
        check("R10 config lock unaffected", cfg_wen, 1);
        wr(3'd4, 32'h3);
        repeat (20) begin
            @(negedge clk);
            if (req != 0) seen++;
        end
        check("R10 trigger write ignored", seen, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_disabled();
        t_sw_trigger();
        t_merge_sw();
        t_auto_bound();
        t_merge_timer();
        t_timeout_ok();
        t_timeout_fire();
        t_cfg_lock();
        t_trig_lock();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule